// File: doc/BRIEF.md
# DMA Descriptor Queue Register Front-End

This block is the register-mapped control side of a single-channel DMA engine. Software fills a set of staging registers (addresses, lengths, strides and a mode flag), then commits them with a single write. The commit pushes the staged transfer into a small descriptor queue and tags it with a rolling transfer ID. The data mover pulls descriptors from the queue through a valid/ready handshake, and it reports each finished transfer by returning its ID on a completion strobe.

The block keeps a per-ID completion mask and two interrupt causes. The start cause fires when a queue slot frees up. The end cause fires when a completion arrives. Both causes have a write-one-to-clear pending register and a mask. A cyclic descriptor stays at the head of the queue and is offered again after each completion, so it needs no new commit.

Top module: `dmaq_regs`

## Requirements
- R1: After reset, control reads 0, mask (0x080) reads 0x3, pending (0x084) reads 0, done (0x428) reads 0, next ID (0x404) reads 0, start (0x408) reads 0, `irq` is low and `desc_valid` is low.
- R2: The staging registers (destination address 0x410, source address 0x414, X length 0x418, Y length 0x41C, destination stride 0x420, source stride 0x424) and the mode register 0x40C (bit 0 = cyclic) read back what was written. Writing 1 to 0x408 while control bit 0 (enable) is set and the queue is not full enqueues the staged set under the ID shown at 0x404. After that, 0x404 reads the old ID + 1 modulo QDEPTH. A commit while enable is clear or the queue is full is ignored.
- R3: The start register 0x408 reads 1 while the queue holds QDEPTH entries and 0 otherwise.
- R4: `desc_valid` is high only when the queue is non-empty, enable is set and control bit 1 (pause) is clear. Descriptors appear in commit order with their staged fields and ID. The outputs hold steady until `desc_ready`.
- R5: A handshake on a non-cyclic descriptor frees its slot and sets pending bit 0 (start of transfer).
- R6: `cmpl_valid` sets done bit [`cmpl_id`] and pending bit 1 (end of transfer). A commit clears the done bit of the ID it assigns.
- R7: Writing a 1 to a pending bit clears it. Writing 0 leaves it unchanged.
- R8: `irq` is the OR of pending bits whose mask bit is 0. Register 0x088 reads pending AND NOT mask.
- R9: Writing control with bit 0 clear flushes the queue. The next ID keeps counting.
- R10: A cyclic descriptor that is accepted is not freed and raises no start cause. It is withheld until a completion with its ID arrives, then it is offered again with the same ID and fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| mover_en | output | 1 | Control enable bit |
| mover_pause | output | 1 | Control pause bit |
| desc_valid | output | 1 | Descriptor offered to the data mover |
| desc_ready | input | 1 | Data mover accepts the descriptor |
| desc_id | output | ID_W | Transfer ID of the offered descriptor |
| desc_dst_addr | output | 32 | Destination address |
| desc_src_addr | output | 32 | Source address |
| desc_x_len | output | 32 | X length field |
| desc_y_len | output | 32 | Y length field |
| desc_dst_stride | output | 32 | Destination stride |
| desc_src_stride | output | 32 | Source stride |
| desc_cyclic | output | 1 | Cyclic mode of the offered descriptor |
| cmpl_valid | input | 1 | Completion strobe from the data mover |
| cmpl_id | input | ID_W | ID of the finished transfer |
| irq | output | 1 | Interrupt request |

## Verification
The bench fills the queue to its depth and checks several things there: the busy readback, that a fifth commit neither advances the ID nor overwrites a slot, and that the ID wraps to zero. A design with an off-by-one full flag would show a busy readback one commit early, or would lose the first descriptor. The bench also reuses IDs whose done bits are set, which exposes a done mask that never clears. It masks one cause while that cause is pending, which exposes an interrupt that ignores the mask. It flushes a full queue, which exposes stale descriptors that survive a disable. Finally it runs a cyclic descriptor through a completion: a design that frees the cyclic slot or re-offers it early would drop it or hand out a second copy before it finished.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;

   typedef struct packed {
      logic [31:0] dst_addr;
      logic [31:0] src_addr;
      logic [31:0] x_len;
      logic [31:0] y_len;
      logic [31:0] dst_stride;
      logic [31:0] src_stride;
      logic        cyclic;
   } xfer_t;

   localparam logic [15:0] OFS_IRQ_MASK  = 16'h0080;
   localparam logic [15:0] OFS_IRQ_PEND  = 16'h0084;
   localparam logic [15:0] OFS_IRQ_SRC   = 16'h0088;
   localparam logic [15:0] OFS_CTRL      = 16'h0400;
   localparam logic [15:0] OFS_NEXT_ID   = 16'h0404;
   localparam logic [15:0] OFS_START     = 16'h0408;
   localparam logic [15:0] OFS_MODE      = 16'h040C;
   localparam logic [15:0] OFS_DST_ADDR  = 16'h0410;
   localparam logic [15:0] OFS_SRC_ADDR  = 16'h0414;
   localparam logic [15:0] OFS_X_LEN     = 16'h0418;
   localparam logic [15:0] OFS_Y_LEN     = 16'h041C;
   localparam logic [15:0] OFS_DST_STR   = 16'h0420;
   localparam logic [15:0] OFS_SRC_STR   = 16'h0424;
   localparam logic [15:0] OFS_DONE      = 16'h0428;

   localparam int IRQ_SOT = 0;
   localparam int IRQ_EOT = 1;
   localparam int N_IRQ   = 2;

endpackage

// File: rtl/dmaq_fifo.sv
module dmaq_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [W-1:0]     wr_data,
   input  logic             pop,
   output logic [W-1:0]     rd_data,
   output logic [CNT_W-1:0] count,
   output logic             full,
   output logic             empty
);
   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wptr, rptr;
   logic             do_push, do_pop;

   assign full    = (count == CNT_W'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rd_data = mem[rptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (do_push) wptr <= wptr + 1'b1;
         if (do_pop)  rptr <= rptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/dmaq_irq.sv
module dmaq_irq #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic         ack_wr,
   input  logic [N-1:0] ack_bits,
   input  logic         mask_wr,
   input  logic [N-1:0] mask_bits,
   output logic [N-1:0] pend,
   output logic [N-1:0] mask,
   output logic [N-1:0] active,
   output logic         irq
);
   for (genvar i = 0; i < N; i++) begin : g_src
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pend[i] <= 1'b0;
            mask[i] <= 1'b1;
         end else begin
            if (set[i])                     pend[i] <= 1'b1;
            else if (ack_wr && ack_bits[i]) pend[i] <= 1'b0;
            if (mask_wr) mask[i] <= mask_bits[i];
         end
      end
   end

   assign active = pend & ~mask;
   assign irq    = |active;
endmodule

// File: rtl/dmaq_regs.sv
module dmaq_regs #(
   parameter int QDEPTH = 4,
   parameter int ADDR_W = 12,
   localparam int ID_W  = $clog2(QDEPTH),
   localparam int CNT_W = $clog2(QDEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              mover_en,
   output logic              mover_pause,
   output logic              desc_valid,
   input  logic              desc_ready,
   output logic [ID_W-1:0]   desc_id,
   output logic [31:0]       desc_dst_addr,
   output logic [31:0]       desc_src_addr,
   output logic [31:0]       desc_x_len,
   output logic [31:0]       desc_y_len,
   output logic [31:0]       desc_dst_stride,
   output logic [31:0]       desc_src_stride,
   output logic              desc_cyclic,
   input  logic              cmpl_valid,
   input  logic [ID_W-1:0]   cmpl_id,
   output logic              irq
);
   import dmaq_pkg::*;

   localparam int QW = $bits(xfer_t) + ID_W;

   if (QDEPTH < 2 || (QDEPTH & (QDEPTH - 1)) != 0 || QDEPTH > 32) begin : g_bad_depth
      $error("QDEPTH must be a power of two between 2 and 32");
   end
   if (ADDR_W < 11 || ADDR_W > 16) begin : g_bad_addr
      $error("ADDR_W must lie between 11 and 16");
   end

   logic [15:0] a16;
   assign a16 = 16'(reg_addr);

   function automatic logic hit(input logic [15:0] ofs);
      return reg_wr_en && (a16 == ofs);
   endfunction

   // staging and control state
   xfer_t             stage;
   logic              ctrl_en, ctrl_pause;
   logic [ID_W-1:0]   next_id;
   logic [QDEPTH-1:0] done_q;
   logic              cyc_wait;

   // queue signals
   logic [QW-1:0]     q_head;
   logic [CNT_W-1:0]  q_count;
   logic              q_full, q_empty;
   logic              flush, commit, handshake, pop;
   xfer_t             head;
   logic [ID_W-1:0]   head_id;

   logic [N_IRQ-1:0]  irq_pend, irq_mask, irq_act, irq_set;

   assign flush     = hit(OFS_CTRL) && !reg_wdata[0];
   assign commit    = hit(OFS_START) && reg_wdata[0] && ctrl_en && !q_full;
   assign {head_id, head} = q_head;
   assign desc_valid = !q_empty && ctrl_en && !ctrl_pause && !cyc_wait;
   assign handshake = desc_valid && desc_ready;
   assign pop       = handshake && !head.cyclic;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage      <= '0;
         ctrl_en    <= 1'b0;
         ctrl_pause <= 1'b0;
         next_id    <= '0;
         cyc_wait   <= 1'b0;
      end else begin
         if (hit(OFS_CTRL)) begin
            ctrl_en    <= reg_wdata[0];
            ctrl_pause <= reg_wdata[1];
         end
         if (hit(OFS_DST_ADDR)) stage.dst_addr   <= reg_wdata;
         if (hit(OFS_SRC_ADDR)) stage.src_addr   <= reg_wdata;
         if (hit(OFS_X_LEN))    stage.x_len      <= reg_wdata;
         if (hit(OFS_Y_LEN))    stage.y_len      <= reg_wdata;
         if (hit(OFS_DST_STR))  stage.dst_stride <= reg_wdata;
         if (hit(OFS_SRC_STR))  stage.src_stride <= reg_wdata;
         if (hit(OFS_MODE))     stage.cyclic     <= reg_wdata[0];
         if (commit) next_id <= next_id + 1'b1;
         if (flush)
            cyc_wait <= 1'b0;
         else if (handshake && head.cyclic)
            cyc_wait <= 1'b1;
         else if (cmpl_valid && cyc_wait && cmpl_id == head_id)
            cyc_wait <= 1'b0;
      end
   end

   // done mask: completion set wins over commit clear
   for (genvar i = 0; i < QDEPTH; i++) begin : g_done
      always_ff @(posedge clk) begin
         if (!rst_n)
            done_q[i] <= 1'b0;
         else if (cmpl_valid && cmpl_id == ID_W'(i))
            done_q[i] <= 1'b1;
         else if (commit && next_id == ID_W'(i))
            done_q[i] <= 1'b0;
      end
   end

   dmaq_fifo #(.W(QW), .DEPTH(QDEPTH)) u_queue (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush),
      .push    (commit),
      .wr_data ({next_id, stage}),
      .pop     (pop),
      .rd_data (q_head),
      .count   (q_count),
      .full    (q_full),
      .empty   (q_empty)
   );

   always_comb begin
      irq_set          = '0;
      irq_set[IRQ_SOT] = pop;
      irq_set[IRQ_EOT] = cmpl_valid;
   end

   dmaq_irq #(.N(N_IRQ)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .set       (irq_set),
      .ack_wr    (hit(OFS_IRQ_PEND)),
      .ack_bits  (reg_wdata[N_IRQ-1:0]),
      .mask_wr   (hit(OFS_IRQ_MASK)),
      .mask_bits (reg_wdata[N_IRQ-1:0]),
      .pend      (irq_pend),
      .mask      (irq_mask),
      .active    (irq_act),
      .irq       (irq)
   );

   always_comb begin
      case (a16)
         OFS_IRQ_MASK: reg_rdata = 32'(irq_mask);
         OFS_IRQ_PEND: reg_rdata = 32'(irq_pend);
         OFS_IRQ_SRC:  reg_rdata = 32'(irq_act);
         OFS_CTRL:     reg_rdata = {30'd0, ctrl_pause, ctrl_en};
         OFS_NEXT_ID:  reg_rdata = 32'(next_id);
         OFS_START:    reg_rdata = {31'd0, q_full};
         OFS_MODE:     reg_rdata = {31'd0, stage.cyclic};
         OFS_DST_ADDR: reg_rdata = stage.dst_addr;
         OFS_SRC_ADDR: reg_rdata = stage.src_addr;
         OFS_X_LEN:    reg_rdata = stage.x_len;
         OFS_Y_LEN:    reg_rdata = stage.y_len;
         OFS_DST_STR:  reg_rdata = stage.dst_stride;
         OFS_SRC_STR:  reg_rdata = stage.src_stride;
         OFS_DONE:     reg_rdata = 32'(done_q);
         default:      reg_rdata = '0;
      endcase
   end

   assign mover_en        = ctrl_en;
   assign mover_pause     = ctrl_pause;
   assign desc_id         = head_id;
   assign desc_dst_addr   = head.dst_addr;
   assign desc_src_addr   = head.src_addr;
   assign desc_x_len      = head.x_len;
   assign desc_y_len      = head.y_len;
   assign desc_dst_stride = head.dst_stride;
   assign desc_src_stride = head.src_stride;
   assign desc_cyclic     = head.cyclic;
endmodule

// File: rtl/dmaq_regs_chk.sv
module dmaq_regs_chk #(
   parameter int QDEPTH = 4,
   parameter int ADDR_W = 12,
   localparam int ID_W  = $clog2(QDEPTH),
   localparam int CNT_W = $clog2(QDEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr_en,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              desc_valid,
   input logic              desc_ready,
   input logic [ID_W-1:0]   desc_id,
   input logic              desc_cyclic,
   input logic              cmpl_valid,
   input logic [ID_W-1:0]   cmpl_id,
   input logic [CNT_W-1:0]  q_count,
   input logic [QDEPTH-1:0] done_q,
   input logic [1:0]        pend_q
);
   logic ctrl_wr;
   assign ctrl_wr = reg_wr_en && (16'(reg_addr) == 16'h0400);

   a_r3_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
      q_count <= CNT_W'(QDEPTH));

   a_r4_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid && !desc_ready && !ctrl_wr |=> desc_valid && $stable(desc_id));

   a_r5_sot_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid && desc_ready && !desc_cyclic |=> pend_q[0]);

   a_r6_done_marked: assert property (@(posedge clk) disable iff (!rst_n)
      cmpl_valid |=> done_q[$past(cmpl_id)] && pend_q[1]);

   a_r10_cyclic_withheld: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid && desc_ready && desc_cyclic |=> !desc_valid);
endmodule

bind dmaq_regs dmaq_regs_chk #(.QDEPTH(QDEPTH), .ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_wr_en   (reg_wr_en),
   .reg_addr    (reg_addr),
   .desc_valid  (desc_valid),
   .desc_ready  (desc_ready),
   .desc_id     (desc_id),
   .desc_cyclic (desc_cyclic),
   .cmpl_valid  (cmpl_valid),
   .cmpl_id     (cmpl_id),
   .q_count     (q_count),
   .done_q      (done_q),
   .pend_q      (irq_pend)
);

// File: tb/dmaq_regs_tb.sv
module dmaq_regs_tb;
   localparam int QDEPTH = 4;
   localparam int ADDR_W = 12;
   localparam int ID_W   = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_wr_en = 1'b0;
   logic [ADDR_W-1:0] reg_addr = '0;
   logic [31:0]       reg_wdata = '0;
   logic [31:0]       reg_rdata;
   logic              mover_en, mover_pause, desc_valid, desc_cyclic, irq;
   logic              desc_ready = 1'b0;
   logic [ID_W-1:0]   desc_id;
   logic [31:0]       desc_dst_addr, desc_src_addr, desc_x_len, desc_y_len;
   logic [31:0]       desc_dst_stride, desc_src_stride;
   logic              cmpl_valid = 1'b0;
   logic [ID_W-1:0]   cmpl_id = '0;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   always #5 clk = ~clk;

   dmaq_regs #(.QDEPTH(QDEPTH), .ADDR_W(ADDR_W)) u_dut (.*);

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 20000) begin
         n_fail++;
         $display("FAIL watchdog: run hung, actual cycle %0d expected < 20000", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic rchk(input string tag, input logic [11:0] a, input logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      chk(tag, d, exp);
   endtask

   task automatic accept();
      @(negedge clk); desc_ready = 1'b1;
      @(negedge clk); desc_ready = 1'b0;
   endtask

   task automatic complete(input logic [ID_W-1:0] id);
      @(negedge clk); cmpl_valid = 1'b1; cmpl_id = id;
      @(negedge clk); cmpl_valid = 1'b0;
   endtask

   // {offset, write data, expected readback}
   localparam logic [75:0] TBL [10] = '{
      {12'h410, 32'h1000_0000, 32'h1000_0000},
      {12'h414, 32'h2000_0040, 32'h2000_0040},
      {12'h418, 32'h0000_00FF, 32'h0000_00FF},
      {12'h41C, 32'h0000_0003, 32'h0000_0003},
      {12'h420, 32'h0000_0400, 32'h0000_0400},
      {12'h424, 32'h0000_0800, 32'h0000_0800},
      {12'h40C, 32'hFFFF_FFFF, 32'h0000_0001},
      {12'h40C, 32'h0000_0000, 32'h0000_0000},
      {12'h080, 32'h0000_0002, 32'h0000_0002},
      {12'h080, 32'h0000_0003, 32'h0000_0003}
   };

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rchk("R1 ctrl", 12'h400, 32'h0);
      rchk("R1 mask", 12'h080, 32'h3);
      rchk("R1 pending", 12'h084, 32'h0);
      rchk("R1 done", 12'h428, 32'h0);
      rchk("R1 next id", 12'h404, 32'h0);
      rchk("R1 start", 12'h408, 32'h0);
      chk("R1 irq", 32'(irq), 32'h0);
      chk("R1 desc_valid", 32'(desc_valid), 32'h0);

      // R2 staging readback table
      foreach (TBL[i]) begin
         wr(TBL[i][75:64], TBL[i][63:32]);
         rchk("R2 staging readback", TBL[i][75:64], TBL[i][31:0]);
      end

      // R2 commit while disabled is ignored
      wr(12'h408, 32'h1);
      rchk("R2 disabled commit id", 12'h404, 32'h0);
      chk("R2 disabled commit valid", 32'(desc_valid), 32'h0);

      // R2/R3/R4 fill the queue while paused
      wr(12'h400, 32'h3);
      for (int i = 0; i < QDEPTH; i++) begin
         rchk("R3 not busy before commit", 12'h408, 32'h0);
         wr(12'h418, 32'h100 + i);
         wr(12'h408, 32'h1);
         rchk("R2 id advance", 12'h404, 32'((i + 1) % QDEPTH));
      end
      rchk("R3 busy when full", 12'h408, 32'h1);
      chk("R4 paused no valid", 32'(desc_valid), 32'h0);
      wr(12'h418, 32'h999);
      wr(12'h408, 32'h1);
      rchk("R2 full commit id unchanged", 12'h404, 32'h0);

      // R4 release pause and check order
      wr(12'h080, 32'h0);
      wr(12'h400, 32'h1);
      chk("R4 valid", 32'(desc_valid), 32'h1);
      chk("R4 head id", 32'(desc_id), 32'h0);
      chk("R4 head xlen", desc_x_len, 32'h100);
      chk("R4 head dst", desc_dst_addr, 32'h1000_0000);
      accept();
      rchk("R5 sot pending", 12'h084, 32'h1);
      chk("R8 irq unmasked", 32'(irq), 32'h1);
      rchk("R8 source", 12'h088, 32'h1);
      rchk("R3 slot freed", 12'h408, 32'h0);
      chk("R4 second id", 32'(desc_id), 32'h1);
      chk("R4 second xlen", desc_x_len, 32'h101);

      // R7 write-one-to-clear
      wr(12'h084, 32'h0);
      rchk("R7 zero write keeps", 12'h084, 32'h1);
      wr(12'h084, 32'h1);
      rchk("R7 cleared", 12'h084, 32'h0);
      chk("R7 irq low", 32'(irq), 32'h0);

      // R8 masked cause
      wr(12'h080, 32'h1);
      accept();
      rchk("R8 masked still pending", 12'h084, 32'h1);
      chk("R8 masked irq low", 32'(irq), 32'h0);
      rchk("R8 masked source", 12'h088, 32'h0);

      // R6 completions
      complete(2'd0);
      rchk("R6 done id0", 12'h428, 32'h1);
      rchk("R6 eot pending", 12'h084, 32'h3);
      chk("R8 eot unmasked irq", 32'(irq), 32'h1);
      complete(2'd1);
      rchk("R6 done id1", 12'h428, 32'h3);

      // R6 done bit cleared on ID reuse
      wr(12'h408, 32'h1);
      rchk("R6 reuse id0 clears", 12'h428, 32'h2);
      wr(12'h408, 32'h1);
      rchk("R6 reuse id1 clears", 12'h428, 32'h0);
      rchk("R3 full again", 12'h408, 32'h1);

      // R9 flush
      wr(12'h400, 32'h0);
      chk("R9 flush valid", 32'(desc_valid), 32'h0);
      rchk("R9 flush start", 12'h408, 32'h0);
      wr(12'h400, 32'h1);
      chk("R9 empty after reenable", 32'(desc_valid), 32'h0);
      rchk("R9 id keeps counting", 12'h404, 32'h2);

      // R10 cyclic
      wr(12'h084, 32'h3);
      wr(12'h40C, 32'h1);
      wr(12'h418, 32'h55);
      wr(12'h408, 32'h1);
      wr(12'h40C, 32'h0);
      wr(12'h418, 32'h66);
      wr(12'h408, 32'h1);
      chk("R10 cyclic offered", 32'(desc_cyclic), 32'h1);
      chk("R10 cyclic id", 32'(desc_id), 32'h2);
      accept();
      chk("R10 withheld", 32'(desc_valid), 32'h0);
      rchk("R10 no sot", 12'h084, 32'h0);
      complete(2'd2);
      chk("R10 reoffered", 32'(desc_valid), 32'h1);
      chk("R10 same id", 32'(desc_id), 32'h2);
      chk("R10 same xlen", desc_x_len, 32'h55);
      rchk("R10 done bit", 12'h428, 32'h4);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule